// File: doc/BRIEF.md
# Expansion Bus Reset Driver

This block drives the active-high reset line for devices on the ISA expansion bus. It has two sources of reset. The first is the power supply: the line stays asserted from power-up until the power-good input has been seen high. If power-good drops later, the line is asserted again and held until power-good returns. The second is software: a one-cycle request from a hard-reset register write asserts the line for at least one millisecond.

Power-good is asynchronous, so it passes through a two-flop synchronizer before it is used. The one-millisecond minimum is counted in clock cycles. The count is derived from the clock-frequency and duration parameters and is rounded up so the pulse is never shorter than asked. A request that arrives while a pulse is running reloads the count, so the pulse then ends a full period after the latest request. The output is high whenever either source asks for reset. The chip-level reset input forces the output high and clears any pending pulse.

Top module: `xbus_rst_drv`

## Requirements
- R1: While `rst_n` is low, `bus_rst` is 1, and it becomes 1 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: After `rst_n` is released, `bus_rst` stays 1 for as long as `pwr_good` is 0.
- R3: With no pulse pending, `bus_rst` goes to 0 after the second rising edge that samples `pwr_good` high, and not before.
- R4: A `hard_rst_req` sampled high at a rising edge makes `bus_rst` 1 for exactly HOLD_CYC clock cycles after that edge. HOLD_CYC = ceil(CLK_HZ * MIN_US / 1e6).
- R5: A new `hard_rst_req` during an active pulse restarts the count, so `bus_rst` stays 1 for HOLD_CYC cycles after the latest request.
- R6: When `pwr_good` falls, `bus_rst` is 1 from the second rising edge that samples it low. It stays 1 until the second rising edge after `pwr_good` is sampled high again.
- R7: The pulse count keeps running while `pwr_good` is low, and `bus_rst` is the OR of the synchronized power-fail condition and the active pulse.
- R8: Asserting `rst_n` cancels a running pulse, so after release only `pwr_good` decides when `bus_rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Chip-level asynchronous reset, active low |
| pwr_good | input | 1 | Asynchronous power-good indication, high when supplies are valid |
| hard_rst_req | input | 1 | One-cycle hard-reset request from the reset-control register write |
| bus_rst | output | 1 | Expansion bus reset, active high |

## Verification
A synchronizer stage that is stuck, skipped or doubled moves the edges of `bus_rst` one cycle relative to `pwr_good`. The exact-latency checks show this two edges after every transition of `pwr_good`. A wrong load value, a bad decrement or a missing restart changes the length of the software pulse. The pulse is measured cycle by cycle, so the error appears within HOLD_CYC cycles of the request. A counter that is not cleared by reset shows up as a late fall of `bus_rst` right after release.

// File: rtl/xbus_rst_drv.sv
module xbus_rst_drv #(
  parameter int CLK_HZ = 50_000_000,
  parameter int MIN_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic hard_rst_req,
  output logic bus_rst
);

  localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(MIN_US) + 64'd999_999) / 64'd1_000_000;
  localparam int     HOLD_CYC = (HOLD_L < 1) ? 1 : int'(HOLD_L);
  localparam int     CW       = $clog2(HOLD_CYC + 1);

  logic          pg_meta, pg_sync;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_meta <= 1'b0;
      pg_sync <= 1'b0;
    end else begin
      pg_meta <= pwr_good;
      pg_sync <= pg_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_cnt <= '0;
    else if (hard_rst_req)     hold_cnt <= CW'(HOLD_CYC);
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - CW'(1);
  end

  assign bus_rst = !pg_sync || (hold_cnt != '0);

endmodule

// File: rtl/xbus_rst_drv_chk.sv
module xbus_rst_drv_chk #(
  parameter int HOLD = 50
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic hard_rst_req,
  input logic bus_rst
);

  localparam int W = $clog2(HOLD + 1);
  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (hard_rst_req)  left <= W'(HOLD);
    else if (left != '0)    left <= left - W'(1);
  end

  assert_reset_drives_R1: assert property (@(posedge clk) !rst_n |-> bus_rst);

  assert_pulse_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_req |=> bus_rst);

  assert_pulse_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (left != '0) |-> bus_rst);

  assert_power_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_good, 2) == 1'b0) |-> bus_rst);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_good, 2) == 1'b1 && $past(rst_n) && $past(rst_n, 2) && left == '0) |-> !bus_rst);

endmodule

bind xbus_rst_drv xbus_rst_drv_chk #(.HOLD(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
  .hard_rst_req(hard_rst_req), .bus_rst(bus_rst)
);

// File: tb/xbus_rst_drv_bench.sv
`timescale 1ns/1ps
module xbus_rst_drv_bench;
  localparam int CLK_HZ = 50_000;
  localparam int MIN_US = 1000;
  localparam int HOLD   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_good = 1'b0, hard_rst_req = 1'b0;
  logic bus_rst;
  int checks = 0, errors = 0;
  bit m_p1 = 0, m_p2 = 0;
  int m_rem = 0;

  always #10 clk = ~clk;

  xbus_rst_drv #(.CLK_HZ(CLK_HZ), .MIN_US(MIN_US)) u_xbus_rst_drv (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .hard_rst_req(hard_rst_req), .bus_rst(bus_rst));

  function automatic bit expect_rst(bit p2, int rem);
    return !p2 || (rem != 0);
  endfunction

  task automatic check(string tag, logic exp);
    checks++;
    if (bus_rst !== exp) begin
      errors++;
      $display("FAIL %s: bus_rst=%b expected %b at %0t", tag, bus_rst, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin m_p1 = 0; m_p2 = 0; m_rem = 0; end
    else begin
      m_p2 = m_p1; m_p1 = pwr_good;
      if (hard_rst_req) m_rem = HOLD;
      else if (m_rem > 0) m_rem--;
    end
    @(negedge clk);
    hard_rst_req = 1'b0;
  endtask

  task automatic count_high(string tag, int exp_len);
    int n = 0;
    while (bus_rst === 1'b1 && n < 4 * HOLD) begin n++; tick(); end
    checks++;
    if (n != exp_len) begin
      errors++;
      $display("FAIL %s: pulse length %0d expected %0d", tag, n, exp_len);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    pwr_good = 1'b1;
    tick(); check("R1", 1'b1);
    tick(); tick(); check("R1", 1'b1);
    rst_n = 1'b1; pwr_good = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); check("R2", 1'b1); end
    pwr_good = 1'b1;
    tick(); check("R3", 1'b1);
    tick(); check("R3", 1'b0);
    tick(); check("R3", 1'b0);

    hard_rst_req = 1'b1;
    tick(); count_high("R4", HOLD);
    check("R4", 1'b0);

    hard_rst_req = 1'b1;
    tick();
    for (int i = 0; i < 19; i++) tick();
    hard_rst_req = 1'b1;
    tick(); count_high("R5", HOLD);

    pwr_good = 1'b0;
    tick(); check("R6", 1'b0);
    tick(); check("R6", 1'b1);
    for (int i = 0; i < 4; i++) tick();
    pwr_good = 1'b1;
    tick(); check("R6", 1'b1);
    tick(); check("R6", 1'b0);

    hard_rst_req = 1'b1;
    tick();
    for (int i = 0; i < 10; i++) tick();
    pwr_good = 1'b0;
    for (int i = 0; i < 12; i++) tick();
    pwr_good = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick(); check("R7", expect_rst(m_p2, m_rem));
    end

    hard_rst_req = 1'b1;
    tick(); tick();
    check("R4", 1'b1);
    #3 rst_n = 1'b0;
    #1 check("R1", 1'b1);
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    tick(); check("R8", 1'b1);
    tick(); check("R8", 1'b0);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) pwr_good = ~pwr_good;
      if ($urandom_range(59) == 0) hard_rst_req = 1'b1;
      tick();
      check("R7", expect_rst(m_p2, m_rem));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule